// File: doc/BRIEF.md
# Shared-Port Micro-op Dispatch Arbiter

This block picks ready micro-ops out of a pool of waiting entries and sends at most one to each of five issue ports in every cycle. Port 0 feeds the full integer unit (simple ALU work plus shifts and integer divide). Port 1 is shared by a reduced integer unit (add-type ALU work and branch targets only) and the floating-point unit. The floating-point unit includes a pipelined adder and multiplier, and non-pipelined divide and square-root engines. Ports 2, 3 and 4 feed the load unit, the store-address unit and the store-data unit.

Each pool entry presents a valid bit, a ready bit, a 4-bit unit class, a precision bit and an age value. On every port the oldest eligible entry wins. The grants are combinational, so the pool owner clears the granted entries at the same clock edge. Two pieces of state guard port 1. The first is a countdown that keeps a second divide or square root out while one is running. The second is a write-back reservation vector that stops two port-1 results from landing in the same cycle. An op that would collide stays in the pool and is granted in a later cycle.

Top module: `dsp_dispatch_arbiter`

## Requirements
- R1: Class codes are ALU=0, SHIFT/IDIV=1, FADD=2, FMUL=3, FDIV=4, FSQRT=5, LOAD=6, STORE-ADDR=7, STORE-DATA=8. Code 0 may use port 0 or port 1. Code 1 uses only port 0. Codes 2 to 5 use only port 1. Codes 6, 7 and 8 use ports 2, 3 and 4 respectively.
- R2: An entry is considered only when both its valid bit and its ready bit are 1.
- R3: Among the eligible entries for a port, the one with the smallest age value is granted. On equal ages the lower entry index wins.
- R4: Port 0 is decided first, over integer entries. Port 1 then takes the oldest among the FP entries and the code-0 entries that port 0 did not take. The integer pair therefore carries either two integer ops or one integer op and one FP op.
- R5: In each cycle, each port grants at most one entry, and no entry is granted on two ports. `gnt_clr_o` has a 1 exactly at the granted entries.
- R6: If an FDIV or FSQRT is granted in cycle t, no FDIV or FSQRT is granted before cycle t+29 when its precision bit is 0, or before t+69 when the bit is 1. The next one may be granted in exactly that cycle.
- R7: While a divide or square root is running, FADD, FMUL and code-0 ops can still be granted on port 1.
- R8: Port-1 result latencies are 1 for code 0, 3 for FADD and 5 for FMUL. A running divide finishes 29 or 69 cycles after its grant. A port-1 op is held back if its result would land in the same cycle as another port-1 result. It stays pending and is granted once the slot is free.
- R9: While rst_n is low, no grant is made. Reset also ends any running divide and clears all reservations.
- R10: The index field of a port that grants nothing reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_vld_i | input | ENTRIES | Entry holds a micro-op |
| ent_rdy_i | input | ENTRIES | Entry operands are ready |
| ent_cls_i | input | ENTRIES*4 | Unit class per entry, entry e at bits [4e+3:4e] |
| ent_xprec_i | input | ENTRIES | Extended precision for divide or square root |
| ent_age_i | input | ENTRIES*AGE_W | Age per entry, smaller is older |
| gnt_vld_o | output | 5 | Grant valid per port, bit p for port p |
| gnt_idx_o | output | 5*log2(ENTRIES) | Granted entry index per port, port p at field p |
| gnt_clr_o | output | ENTRIES | Entries dispatched this cycle, to be removed from the pool |

## Verification
The hardest case to reach from the ports is a write-back clash between a pipelined op and a divide that is still running. It only occurs when the divide's remaining cycle count equals the new op's latency, one cycle late in a 29-cycle window. The stimulus counts cycles from the divide grant. It offers an FADD exactly three cycles before the divide ends, and then again one cycle later. It also staggers FMUL and FADD offers to hit the pipelined-versus-pipelined clash and the code-0 clash. Reset is asserted in the middle of a long divide to show that the countdown is dropped.

// File: rtl/dsp_pkg.sv
// Shared definitions for the micro-op dispatch arbiter.
// Class encodings are visible at the block ports and must stay fixed.
package dsp_pkg;

    localparam int NPORTS = 5;
    localparam int CLS_W  = 4;

    typedef enum logic [CLS_W-1:0] {
        UC_ALU    = 4'd0,
        UC_SHDIV  = 4'd1,
        UC_FADD   = 4'd2,
        UC_FMUL   = 4'd3,
        UC_FDIV   = 4'd4,
        UC_FSQRT  = 4'd5,
        UC_LOAD   = 4'd6,
        UC_STADDR = 4'd7,
        UC_STDATA = 4'd8
    } ucls_e;

    localparam int P_FULL = 0;
    localparam int P_SHR  = 1;
    localparam int P_MEM0 = 2;

endpackage

// File: rtl/dsp_oldest_pick.sv
// Oldest-first selector.
// From a mask of eligible entries it returns the one with the smallest age.
// On equal ages the lower index wins.
// Assumes nothing about uniqueness of ages.
// With no eligible entry, found_o is low and idx_o is zero.
module dsp_oldest_pick #(
    parameter int ENTRIES = 8,
    parameter int AGE_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       elig_i,
    input  logic [ENTRIES*AGE_W-1:0] age_i,
    output logic                     found_o,
    output logic [IDX_W-1:0]         idx_o
);

    logic [AGE_W-1:0] best_age;

    // Linear scan keeping the strictly older candidate.
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        best_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (elig_i[i] && (!found_o || age_i[i*AGE_W +: AGE_W] < best_age)) begin
                found_o  = 1'b1;
                idx_o    = IDX_W'(i);
                best_age = age_i[i*AGE_W +: AGE_W];
            end
        end
    end

endmodule

// File: rtl/dsp_elig_decode.sv
// Per-entry eligibility decode.
// Turns valid, ready and class into one candidate mask per port.
// For port 1 it also folds in the occupancy verdicts from the shared-port tracker.
// Assumes run_i is low during reset, so that no candidate appears then.
module dsp_elig_decode
    import dsp_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                     run_i,
    input  logic [ENTRIES-1:0]       vld_i,
    input  logic [ENTRIES-1:0]       rdy_i,
    input  logic [ENTRIES*CLS_W-1:0] cls_i,
    input  logic                     ok_alu_i,
    input  logic                     ok_fadd_i,
    input  logic                     ok_fmul_i,
    input  logic                     div_free_i,
    output logic [ENTRIES-1:0]       m_full_o,
    output logic [ENTRIES-1:0]       m_shr_o,
    output logic [2:0][ENTRIES-1:0]  m_mem_o
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [CLS_W-1:0] c;
        logic             live;
        logic             long_op;

        // Class slice and liveness of this entry.
        assign c       = cls_i[e*CLS_W +: CLS_W];
        assign live    = run_i & vld_i[e] & rdy_i[e];
        assign long_op = (c == UC_FDIV) || (c == UC_FSQRT);

        // Port 0 takes any integer class.
        assign m_full_o[e] = live & ((c == UC_ALU) || (c == UC_SHDIV));

        // Port 1 takes simple integer and FP work, subject to port occupancy.
        assign m_shr_o[e]  = live & (((c == UC_ALU)  && ok_alu_i)  ||
                                     ((c == UC_FADD) && ok_fadd_i) ||
                                     ((c == UC_FMUL) && ok_fmul_i) ||
                                     (long_op && div_free_i));

        // Memory ports, one class each.
        assign m_mem_o[0][e] = live & (c == UC_LOAD);
        assign m_mem_o[1][e] = live & (c == UC_STADDR);
        assign m_mem_o[2][e] = live & (c == UC_STDATA);
    end

endmodule

// File: rtl/dsp_shared_track.sv
// Port-1 occupancy tracker.
// Holds a countdown for the running non-pipelined divide or square root.
// Also holds a vector of reserved write-back slots for pipelined port-1 results:
// bit j set means a result lands j cycles from now.
// It reports which latencies can still be issued this cycle without a clash.
// Assumes that all pipelined latencies are shorter than the shortest divide.
module dsp_shared_track
    import dsp_pkg::*;
#(
    parameter int LAT_ALU  = 1,
    parameter int LAT_FADD = 3,
    parameter int LAT_FMUL = 5,
    parameter int LAT_DSP  = 29,
    parameter int LAT_DXP  = 69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic             xprec_i,
    output logic             ok_alu_o,
    output logic             ok_fadd_o,
    output logic             ok_fmul_o,
    output logic             div_free_o
);

    localparam int MAX_AF = (LAT_ALU > LAT_FADD) ? LAT_ALU : LAT_FADD;
    localparam int MAXP   = (MAX_AF > LAT_FMUL) ? MAX_AF : LAT_FMUL;
    localparam int OCC_W  = MAXP - 1;
    localparam int REM_W  = $clog2(LAT_DXP + 1);

    logic [OCC_W:1] occ;
    logic [OCC_W:1] occ_n;
    logic [MAXP:1]  taken;
    logic [REM_W-1:0] div_rem;
    logic is_alu, is_fadd, is_fmul, is_long;

    // Class of the op issued on port 1 this cycle.
    assign is_alu  = (cls_i == UC_ALU);
    assign is_fadd = (cls_i == UC_FADD);
    assign is_fmul = (cls_i == UC_FMUL);
    assign is_long = (cls_i == UC_FDIV) || (cls_i == UC_FSQRT);

    // Slot l is taken by a pipelined reservation or by the divide finishing.
    for (genvar l = 1; l <= MAXP; l++) begin : g_taken
        if (l <= OCC_W) begin : g_res
            assign taken[l] = occ[l] | (div_rem == REM_W'(l));
        end else begin : g_top
            assign taken[l] = (div_rem == REM_W'(l));
        end
    end

    // Verdicts per latency class.
    assign ok_alu_o   = !taken[LAT_ALU];
    assign ok_fadd_o  = !taken[LAT_FADD];
    assign ok_fmul_o  = !taken[LAT_FMUL];
    assign div_free_o = (div_rem == '0);

    // Next reservation vector: shift by one and add the new issue.
    for (genvar j = 1; j <= OCC_W; j++) begin : g_occ
        logic setb;
        assign setb = go_i & ((is_alu  && (LAT_ALU  == j + 1)) ||
                              (is_fadd && (LAT_FADD == j + 1)) ||
                              (is_fmul && (LAT_FMUL == j + 1)));
        if (j < OCC_W) begin : g_mid
            assign occ_n[j] = occ[j+1] | setb;
        end else begin : g_end
            assign occ_n[j] = setb;
        end
    end

    // Reservation vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ_n;
    end

    // Countdown of the running divide or square root.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_rem <= '0;
        else if (go_i && is_long)  div_rem <= xprec_i ? REM_W'(LAT_DXP - 1) : REM_W'(LAT_DSP - 1);
        else if (div_rem != '0)    div_rem <= div_rem - REM_W'(1);
    end

    // R6: a long op is only started on an idle engine.
    p_long_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && is_long) |-> (div_rem == '0));

    // R6: a running countdown steps down by exactly one.
    p_rem_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_rem != '0) |=> (div_rem == $past(div_rem) - REM_W'(1)));

    // R8: an issued pipelined op never lands on a taken slot.
    p_slot_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !((is_alu && taken[LAT_ALU]) || (is_fadd && taken[LAT_FADD]) ||
                   (is_fmul && taken[LAT_FMUL])));

endmodule

// File: rtl/dsp_dispatch_arbiter.sv
// Dispatch arbiter for five issue ports.
// Port 0 is the full integer unit.
// Port 1 is shared by the simple integer unit and the FP unit, with its divider.
// Ports 2 to 4 are load, store-address and store-data.
// Port 0 is resolved before port 1 so that an integer entry is never taken twice.
// Grants are combinational; the pool owner drops gnt_clr_o entries at the next edge.
// Assumes entry state is stable between clock edges.
module dsp_dispatch_arbiter
    import dsp_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int AGE_W    = 4,
    parameter int LAT_ALU  = 1,
    parameter int LAT_FADD = 3,
    parameter int LAT_FMUL = 5,
    parameter int LAT_DSP  = 29,
    parameter int LAT_DXP  = 69,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ENTRIES-1:0]       ent_vld_i,
    input  logic [ENTRIES-1:0]       ent_rdy_i,
    input  logic [ENTRIES*CLS_W-1:0] ent_cls_i,
    input  logic [ENTRIES-1:0]       ent_xprec_i,
    input  logic [ENTRIES*AGE_W-1:0] ent_age_i,
    output logic [NPORTS-1:0]        gnt_vld_o,
    output logic [NPORTS*IDX_W-1:0]  gnt_idx_o,
    output logic [ENTRIES-1:0]       gnt_clr_o
);

    logic [ENTRIES-1:0]      m_full, m_shr, m_shr_left, sel0;
    logic [2:0][ENTRIES-1:0] m_mem;
    logic [NPORTS-1:0]       p_found;
    logic [IDX_W-1:0]        p_idx [NPORTS];
    logic [CLS_W-1:0]        sh_cls;
    logic                    sh_xprec;
    logic ok_alu, ok_fadd, ok_fmul, div_free;

    dsp_elig_decode #(.ENTRIES(ENTRIES)) u_dec (
        .run_i      (rst_n),
        .vld_i      (ent_vld_i),
        .rdy_i      (ent_rdy_i),
        .cls_i      (ent_cls_i),
        .ok_alu_i   (ok_alu),
        .ok_fadd_i  (ok_fadd),
        .ok_fmul_i  (ok_fmul),
        .div_free_i (div_free),
        .m_full_o   (m_full),
        .m_shr_o    (m_shr),
        .m_mem_o    (m_mem)
    );

    dsp_oldest_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_pick_full (
        .elig_i  (m_full),
        .age_i   (ent_age_i),
        .found_o (p_found[P_FULL]),
        .idx_o   (p_idx[P_FULL])
    );

    // Remove port 0's choice from port 1's candidates.
    always_comb begin
        sel0 = '0;
        if (p_found[P_FULL]) sel0[p_idx[P_FULL]] = 1'b1;
        m_shr_left = m_shr & ~sel0;
    end

    dsp_oldest_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_pick_shr (
        .elig_i  (m_shr_left),
        .age_i   (ent_age_i),
        .found_o (p_found[P_SHR]),
        .idx_o   (p_idx[P_SHR])
    );

    for (genvar k = 0; k < 3; k++) begin : g_mem
        dsp_oldest_pick #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_pick_mem (
            .elig_i  (m_mem[k]),
            .age_i   (ent_age_i),
            .found_o (p_found[P_MEM0+k]),
            .idx_o   (p_idx[P_MEM0+k])
        );
    end

    // Class and precision of the entry granted on port 1.
    always_comb begin
        sh_cls   = '0;
        sh_xprec = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (p_idx[P_SHR] == IDX_W'(e)) begin
                sh_cls   = ent_cls_i[e*CLS_W +: CLS_W];
                sh_xprec = ent_xprec_i[e];
            end
        end
    end

    dsp_shared_track #(
        .LAT_ALU (LAT_ALU), .LAT_FADD(LAT_FADD), .LAT_FMUL(LAT_FMUL),
        .LAT_DSP (LAT_DSP), .LAT_DXP (LAT_DXP)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (p_found[P_SHR]),
        .cls_i      (sh_cls),
        .xprec_i    (sh_xprec),
        .ok_alu_o   (ok_alu),
        .ok_fadd_o  (ok_fadd),
        .ok_fmul_o  (ok_fmul),
        .div_free_o (div_free)
    );

    // Pack per-port results onto the output buses.
    assign gnt_vld_o = p_found;
    for (genvar p = 0; p < NPORTS; p++) begin : g_out
        assign gnt_idx_o[p*IDX_W +: IDX_W] = p_idx[p];
    end

    // Dispatch mask back to the pool.
    always_comb begin
        gnt_clr_o = '0;
        for (int p = 0; p < NPORTS; p++)
            if (p_found[p]) gnt_clr_o[p_idx[p]] = 1'b1;
    end

    // R5: each granted port removes a distinct entry.
    p_distinct_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_clr_o) == $countones(gnt_vld_o));

    // R1: the shared port never carries shift/divide integer or memory work.
    p_shared_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o[P_SHR] |-> (sh_cls != UC_SHDIV && sh_cls < UC_LOAD));

    // R2: port 0 only dispatches live entries.
    p_live_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o[P_FULL] |-> (ent_vld_i[p_idx[P_FULL]] && ent_rdy_i[p_idx[P_FULL]]));

    // R10: an idle port shows index zero.
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        p_idle_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt_vld_o[p] |-> (gnt_idx_o[p*IDX_W +: IDX_W] == '0));
    end

    // R9: nothing is dispatched while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) p_reset_quiet_r9: assert (gnt_vld_o == '0);
    end

endmodule

// File: tb/dsp_dispatch_arbiter_tb.sv
module dsp_dispatch_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int E  = 8;
    localparam int AW = 4;

    typedef struct packed {
        logic [3:0]  rq;
        logic [7:0]  vld;
        logic [7:0]  rdy;
        logic [31:0] cls;
        logic [31:0] age;
        logic [4:0]  evld;
        logic [14:0] eidx;
    } vec_t;

    // Port p index field is eidx[3p+2:3p]; entry e class/age nibble at [4e+3:4e].
    localparam vec_t TABLE [10] = '{
        '{4'd10, 8'h00, 8'h00, 32'h0000_0000, 32'h0000_0000, 5'b00000, 15'h0000}, // R10 idle
        '{4'd3,  8'h24, 8'h24, 32'h0060_0600, 32'h0030_0700, 5'b00100, 15'h0140}, // R3 older load
        '{4'd2,  8'h24, 8'h04, 32'h0060_0600, 32'h0030_0700, 5'b00100, 15'h0080}, // R2 not ready
        '{4'd4,  8'h09, 8'h09, 32'h0000_0000, 32'h0000_1005, 5'b00011, 15'h0003}, // R4 two ALU
        '{4'd4,  8'h52, 8'h52, 32'h0100_0010, 32'h0002_0060, 5'b00011, 15'h0026}, // R4 shift + ALU
        '{4'd1,  8'h03, 8'h03, 32'h0000_0011, 32'h0000_0001, 5'b00001, 15'h0001}, // R1 shift port 0 only
        '{4'd1,  8'hA9, 8'hA9, 32'h7080_8006, 32'h9020_4008, 5'b11100, 15'h5E00}, // R1 memory ports
        '{4'd3,  8'h42, 8'h42, 32'h0600_0060, 32'h0300_0030, 5'b00100, 15'h0040}, // R3 tie, low index
        '{4'd2,  8'h04, 8'h14, 32'h0006_0600, 32'h0000_0500, 5'b00100, 15'h0080}, // R2 ready not valid
        '{4'd5,  8'h3F, 8'h3F, 32'h0008_7621, 32'h0054_3210, 5'b11111, 15'h4688}  // R5 all ports
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [E-1:0]  vld = '0, rdy = '0, xp = '0;
    logic [4*E-1:0]  cls = '0;
    logic [AW*E-1:0] age = '0;
    logic [4:0]    gnt_vld;
    logic [14:0]   gnt_idx;
    logic [E-1:0]  gnt_clr;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_dispatch_arbiter #(.ENTRIES(E), .AGE_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ent_vld_i(vld), .ent_rdy_i(rdy),
        .ent_cls_i(cls), .ent_xprec_i(xp), .ent_age_i(age),
        .gnt_vld_o(gnt_vld), .gnt_idx_o(gnt_idx), .gnt_clr_o(gnt_clr)
    );

    task automatic empty_pool();
        vld = '0; rdy = '0; xp = '0; cls = '0; age = '0;
    endtask

    task automatic put(input int e, input logic [3:0] c, input logic [3:0] a, input logic x);
        vld[e] = 1'b1; rdy[e] = 1'b1; xp[e] = x;
        cls[e*4 +: 4] = c; age[e*AW +: AW] = a;
    endtask

    task automatic chk(input int rq, input logic [4:0] ev, input logic [14:0] ei, input string what);
        logic [E-1:0] ec = '0;
        for (int p = 0; p < 5; p++) if (ev[p]) ec[ei[p*3 +: 3]] = 1'b1;
        n_chk++;
        if (gnt_vld !== ev || gnt_idx !== ei || gnt_clr !== ec) begin
            n_bad++;
            $display("FAIL R%0d %s: vld %b idx %h clr %b, expected vld %b idx %h clr %b",
                     rq, what, gnt_vld, gnt_idx, gnt_clr, ev, ei, ec);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; empty_pool();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R9: a full pool under reset yields no grant.
        repeat (2) @(negedge clk);
        put(0, 4'd6, 4'd1, 1'b0); put(1, 4'd0, 4'd2, 1'b0); put(2, 4'd4, 4'd3, 1'b0);
        #1 chk(9, 5'b0, 15'h0, "reset quiet R9");
        @(negedge clk); empty_pool(); rst_n = 1'b1;

        // Table of stateless vectors.
        for (int v = 0; v < 10; v++) begin
            @(negedge clk);
            vld = TABLE[v].vld; rdy = TABLE[v].rdy; cls = TABLE[v].cls;
            age = TABLE[v].age; xp = '0;
            #1 chk(int'(TABLE[v].rq), TABLE[v].evld, TABLE[v].eidx, $sformatf("table vec %0d", v));
        end

        // R6/R7/R8: divide occupancy and clash with its completion.
        do_reset();
        @(negedge clk); empty_pool(); put(0, 4'd4, 4'd1, 1'b0);
        #1 chk(6, 5'b00010, 15'h0000, "R6 divide starts");
        @(negedge clk); empty_pool(); put(1, 4'd5, 4'd1, 1'b0); put(2, 4'd2, 4'd2, 1'b0);
        #1 chk(7, 5'b00010, 15'h0010, "R7 add during divide");
        for (int k = 2; k <= 25; k++) begin
            @(negedge clk); empty_pool(); put(1, 4'd5, 4'd1, 1'b0);
            #1 chk(6, 5'b0, 15'h0, $sformatf("R6 sqrt held k=%0d", k));
        end
        @(negedge clk); put(2, 4'd2, 4'd2, 1'b0);
        #1 chk(8, 5'b0, 15'h0, "R8 add clashes with divide end");
        @(negedge clk);
        #1 chk(8, 5'b00010, 15'h0010, "R8 add granted one cycle later");
        @(negedge clk); empty_pool(); put(1, 4'd5, 4'd1, 1'b0);
        #1 chk(6, 5'b0, 15'h0, "R6 last busy cycle");
        @(negedge clk); empty_pool(); put(1, 4'd5, 4'd1, 1'b1);
        #1 chk(6, 5'b00010, 15'h0008, "R6 sqrt at boundary");
        for (int k = 1; k <= 68; k++) begin
            @(negedge clk); empty_pool(); put(3, 4'd4, 4'd1, 1'b0);
            #1 chk(6, 5'b0, 15'h0, $sformatf("R6 extended hold k=%0d", k));
        end
        @(negedge clk);
        #1 chk(6, 5'b00010, 15'h0018, "R6 extended boundary");

        // R8: pipelined write-back clashes.
        do_reset();
        @(negedge clk); empty_pool(); put(0, 4'd3, 4'd1, 1'b0);
        #1 chk(8, 5'b00010, 15'h0000, "R8 mul issued");
        @(negedge clk); empty_pool();
        #1 chk(8, 5'b0, 15'h0, "R8 gap");
        @(negedge clk); put(2, 4'd2, 4'd1, 1'b0);
        #1 chk(8, 5'b0, 15'h0, "R8 add held behind mul");
        @(negedge clk);
        #1 chk(8, 5'b00010, 15'h0010, "R8 add granted when free");
        @(negedge clk); empty_pool(); put(0, 4'd0, 4'd1, 1'b0); put(1, 4'd0, 4'd2, 1'b0);
        #1 chk(8, 5'b00001, 15'h0000, "R8 ALU held off shared port");

        // R9: reset drops a running divide.
        do_reset();
        @(negedge clk); empty_pool(); put(0, 4'd4, 4'd1, 1'b1);
        #1 chk(6, 5'b00010, 15'h0000, "R6 long divide");
        @(negedge clk); empty_pool(); put(1, 4'd5, 4'd1, 1'b0);
        #1 chk(6, 5'b0, 15'h0, "R6 sqrt blocked");
        do_reset();
        @(negedge clk); empty_pool(); put(1, 4'd5, 4'd1, 1'b0);
        #1 chk(9, 5'b00010, 15'h0008, "R9 engine free after reset");

        @(negedge clk);
        finish_run();
    end

endmodule